// File: doc/BRIEF.md
# Fully-Associative Tag Store with Duplicate Scrubbing

This block is the tag side of a small fully-associative cache. It keeps a tag, a valid bit and a dirty bit for each of `SLOTS` slots. Each accepted request compares its tag against every slot at once. It answers with hit or miss and the slot that now holds the line. On a miss it fills a slot: the lowest-index free slot if there is one, otherwise the slot named by a round-robin victim pointer. A dirty victim produces a one-cycle write-back request that carries the tag being displaced. Data storage, refill and the write-back data path belong to neighbouring blocks.

In correct operation no tag may live in two valid slots. A copy can still appear when a fill bypasses the search, as happens when a second agent races the lookup. The `req_nosearch` input models this kind of fill: it allocates a slot without comparing tags. When a later lookup finds several valid copies, the block removes the extra copies in that same lookup cycle. It keeps a dirty copy in preference to a clean one, reports the slot of the copy it kept, and pulses `dup_fault`.

Top module: `dup_scrub_tagstore`

## Requirements
- R1: After reset no slot is valid and all response outputs are 0. The first lookup misses and fills slot 0.
- R2: A lookup whose tag matches exactly one valid slot returns `rsp_hit`=1 and that slot in `rsp_slot`. No slot is allocated and `dup_fault` stays 0.
- R3: A lookup that misses while an invalid slot exists fills the lowest-index invalid slot. It returns `rsp_hit`=0 with that index and raises no write-back.
- R4: A lookup that misses with every slot valid evicts the slot named by the victim pointer and returns that index. The pointer starts at 0 after reset and advances by one on every eviction, wrapping from `SLOTS-1` to 0.
- R5: Evicting a dirty victim pulses `wb_req` for one cycle, with `wb_tag` equal to the victim's old tag. Evicting a clean victim, or filling a free slot, leaves `wb_req` at 0.
- R6: A write hit sets the dirty bit of the slot reported. A write miss fills the slot dirty and a read miss fills it clean.
- R7: When several valid slots match, the surviving copy is chosen as follows. The lowest-index dirty match survives if any match is dirty; otherwise the lowest-index match survives. The response reports the survivor with `rsp_hit`=1 and `dup_fault`=1. Every other matching slot becomes invalid in that same cycle.
- R8: A request with `req_nosearch`=1 ignores tag matches and always allocates by the R3/R4 rules. It returns `rsp_hit`=0 and `dup_fault`=0.
- R9: Response outputs change on the rising edge that accepts `req_valid`. They stay valid for that one cycle only. With `req_valid`=0 all response outputs read 0 in the next cycle and no slot state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_nosearch | input | 1 | Fill without tag search (racing fill) |
| req_tag | input | TAG_W | Request tag |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Tag found in a valid slot |
| rsp_slot | output | $clog2(SLOTS) | Slot that hit or was filled |
| dup_fault | output | 1 | Duplicate copies found and scrubbed |
| wb_req | output | 1 | Dirty victim evicted |
| wb_tag | output | TAG_W | Tag of the evicted dirty victim |

## Verification
Every result is due exactly one cycle after its request: the lookup, fill, scrub and eviction all resolve combinationally and are captured on the edge that accepts the request. The responses, `dup_fault` and `wb_req` are therefore readable from the following falling edge. The bench drives each request on a falling edge and compares all outputs with its model's prediction at the next falling edge. In the same step it updates the model's slot state, so back-to-back requests are checked against the state left by the previous one. Idle cycles are checked the same way, and they must show an all-zero response.

// File: rtl/dsts_pkg.sv
package dsts_pkg;
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_HIT   = 2'd1,
    ACT_FILL  = 2'd2,
    ACT_EVICT = 2'd3
  } dsts_act_e;
endpackage

// File: rtl/dsts_rst_sync.sv
module dsts_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/dsts_match_array.sv
module dsts_match_array #(
  parameter int SLOTS = 8,
  parameter int TAG_W = 12
) (
  input  logic [SLOTS-1:0]            slot_valid,
  input  logic [SLOTS-1:0][TAG_W-1:0] slot_tag,
  input  logic [TAG_W-1:0]            probe_tag,
  output logic [SLOTS-1:0]            hit_vec
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
    assign hit_vec[g] = slot_valid[g] && (slot_tag[g] == probe_tag);
  end
endmodule

// File: rtl/dsts_pick_first.sv
module dsts_pick_first #(
  parameter int W  = 8,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx,
  output logic [W-1:0]  onehot
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
    found  = |vec;
    onehot = vec & (~vec + W'(1));
  end

  // R3 / R7: the reported index is set and nothing below it is set
  always_comb begin
    a_r3_pick_lowest: assert (!found || (vec[idx] && ((vec & ((W'(1) << idx) - W'(1))) == '0)));
  end
endmodule

// File: rtl/dsts_victim_ptr.sv
module dsts_victim_ptr #(
  parameter int SLOTS = 8,
  localparam int IW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  output logic [IW-1:0] ptr
);
  logic [IW-1:0] ptr_d, ptr_q;

  always_comb begin
    ptr_d = ptr_q;
    if (advance) begin
      if (ptr_q == IW'(SLOTS - 1)) ptr_d = '0;
      else                         ptr_d = ptr_q + IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr_q <= '0;
    else if (advance) ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  // R4: each eviction moves the pointer on by exactly one, with wrap
  a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (ptr_q == (($past(ptr_q) == IW'(SLOTS - 1)) ? '0 : $past(ptr_q) + IW'(1))));
  a_r4_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(ptr_q));
endmodule

// File: rtl/dup_scrub_tagstore.sv
module dup_scrub_tagstore #(
  parameter int SLOTS = 8,
  parameter int TAG_W = 12,
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_nosearch,
  input  logic [TAG_W-1:0] req_tag,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [IDX_W-1:0] rsp_slot,
  output logic             dup_fault,
  output logic             wb_req,
  output logic [TAG_W-1:0] wb_tag
);
  import dsts_pkg::*;

  logic rst_sync_n;

  dsts_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // slot state
  logic [SLOTS-1:0]            valid_q, valid_d;
  logic [SLOTS-1:0]            dirty_q, dirty_d;
  logic [SLOTS-1:0][TAG_W-1:0] tag_q;
  logic [SLOTS-1:0]            tag_we;

  // lookup
  logic [SLOTS-1:0] match_vec, dmatch_vec, cmatch_vec, free_vec;
  logic             d_found, c_found, f_found;
  logic [IDX_W-1:0] d_idx, c_idx, f_idx;
  logic [SLOTS-1:0] d_oh, c_oh, f_oh;

  dsts_match_array #(.SLOTS(SLOTS), .TAG_W(TAG_W)) u_match (
    .slot_valid (valid_q),
    .slot_tag   (tag_q),
    .probe_tag  (req_tag),
    .hit_vec    (match_vec)
  );

  assign dmatch_vec = match_vec & dirty_q;
  assign cmatch_vec = match_vec & ~dirty_q;
  assign free_vec   = ~valid_q;

  dsts_pick_first #(.W(SLOTS)) u_pick_dirty (
    .vec (dmatch_vec), .found (d_found), .idx (d_idx), .onehot (d_oh)
  );
  dsts_pick_first #(.W(SLOTS)) u_pick_clean (
    .vec (cmatch_vec), .found (c_found), .idx (c_idx), .onehot (c_oh)
  );
  dsts_pick_first #(.W(SLOTS)) u_pick_free (
    .vec (free_vec), .found (f_found), .idx (f_idx), .onehot (f_oh)
  );

  logic [IDX_W-1:0] vic_idx;
  logic             evict_c;

  dsts_victim_ptr #(.SLOTS(SLOTS)) u_vptr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .advance (evict_c),
    .ptr     (vic_idx)
  );

  // decision
  dsts_act_e        act_c;
  logic             hit_c, dup_c, wb_c;
  logic [SLOTS-1:0] surv_oh, drop_vec;
  logic [IDX_W-1:0] surv_idx, alloc_idx, slot_c;

  always_comb begin
    hit_c    = req_valid && !req_nosearch && (|match_vec);
    surv_oh  = d_found ? d_oh  : c_oh;
    surv_idx = d_found ? d_idx : c_idx;
    dup_c    = hit_c && ($countones(match_vec) > 1);
    drop_vec = hit_c ? (match_vec & ~surv_oh) : '0;

    if (!req_valid)   act_c = ACT_IDLE;
    else if (hit_c)   act_c = ACT_HIT;
    else if (f_found) act_c = ACT_FILL;
    else              act_c = ACT_EVICT;

    evict_c   = (act_c == ACT_EVICT);
    alloc_idx = f_found ? f_idx : vic_idx;
    wb_c      = evict_c && dirty_q[vic_idx];
    slot_c    = (act_c == ACT_HIT) ? surv_idx : alloc_idx;
  end

  // next state
  always_comb begin
    valid_d = valid_q & ~drop_vec;
    dirty_d = dirty_q & ~drop_vec;
    tag_we  = '0;
    case (act_c)
      ACT_HIT: begin
        if (req_write) dirty_d = dirty_d | surv_oh;
      end
      ACT_FILL, ACT_EVICT: begin
        valid_d[alloc_idx] = 1'b1;
        dirty_d[alloc_idx] = req_write;
        tag_we[alloc_idx]  = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (req_valid) begin
      valid_q <= valid_d;
      dirty_q <= dirty_d;
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_tag
    always_ff @(posedge clk) begin
      if (tag_we[g]) tag_q[g] <= req_tag;
    end
  end

  // response registers
  logic             rsp_valid_d, rsp_hit_d, dup_d, wb_d;
  logic [IDX_W-1:0] rsp_slot_d;
  logic [TAG_W-1:0] wb_tag_d;

  always_comb begin
    rsp_valid_d = req_valid;
    rsp_hit_d   = hit_c;
    dup_d       = dup_c;
    wb_d        = wb_c;
    rsp_slot_d  = req_valid ? slot_c : '0;
    wb_tag_d    = wb_c ? tag_q[vic_idx] : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_slot  <= '0;
      dup_fault <= 1'b0;
      wb_req    <= 1'b0;
      wb_tag    <= '0;
    end else begin
      rsp_valid <= rsp_valid_d;
      rsp_hit   <= rsp_hit_d;
      rsp_slot  <= rsp_slot_d;
      dup_fault <= dup_d;
      wb_req    <= wb_d;
      wb_tag    <= wb_tag_d;
    end
  end

  // assertions
  // R9: no request means a quiet response and unchanged slot state next cycle
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> (!rsp_valid && !rsp_hit && !dup_fault && !wb_req && $stable(valid_q) && $stable(dirty_q)));

  // R5 / R7: pulses only ride on a response; a fault is always a hit
  a_r5_wb_with_rsp: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wb_req |-> (rsp_valid && !rsp_hit));
  a_r7_dup_is_hit: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dup_fault |-> (rsp_valid && rsp_hit));

  // R8: a search-less fill never reports a hit
  a_r8_nosearch_miss: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_nosearch) |=> (!rsp_hit && !dup_fault));

  // R7: after a scrub only the survivor of that tag is still valid
  a_r7_one_left: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && hit_c) |=> ($countones(valid_q & $past(match_vec)) == 1));

  // R6: a write hit leaves the reported slot dirty
  a_r6_write_dirty: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && hit_c && req_write) |=> dirty_q[rsp_slot]);

  // R3: a fill into a free slot never asks for write-back
  a_r3_free_no_wb: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && !hit_c && f_found) |=> !wb_req);
endmodule

// File: tb/tb_dup_scrub_tagstore.sv
module tb_dup_scrub_tagstore;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS = 8;
  localparam int TAG_W = 12;
  localparam int IDX_W = $clog2(SLOTS);

  logic             clk = 1'b0;
  logic             rst_n;
  logic             req_valid, req_write, req_nosearch;
  logic [TAG_W-1:0] req_tag;
  logic             rsp_valid, rsp_hit, dup_fault, wb_req;
  logic [IDX_W-1:0] rsp_slot;
  logic [TAG_W-1:0] wb_tag;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dup_scrub_tagstore #(.SLOTS(SLOTS), .TAG_W(TAG_W)) dut (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_write (req_write),
    .req_nosearch (req_nosearch), .req_tag (req_tag),
    .rsp_valid (rsp_valid), .rsp_hit (rsp_hit), .rsp_slot (rsp_slot),
    .dup_fault (dup_fault), .wb_req (wb_req), .wb_tag (wb_tag)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  // bench model of the slot state
  bit          m_valid [SLOTS];
  bit          m_dirty [SLOTS];
  int unsigned m_tag   [SLOTS];
  int          m_ptr;

  bit          e_valid, e_hit, e_dup, e_wb;
  int unsigned e_slot, e_wbtag;

  task automatic chk(input string req, input string what, input int unsigned act, input int unsigned exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < SLOTS; i++) begin
      m_valid[i] = 0; m_dirty[i] = 0; m_tag[i] = 0;
    end
    m_ptr = 0;
  endtask

  task automatic model_step(input bit v, input bit w, input bit ns, input int unsigned t);
    int cnt, surv, lowd, lowm, fr;
    e_valid = v; e_hit = 0; e_dup = 0; e_wb = 0; e_slot = 0; e_wbtag = 0;
    if (!v) return;
    cnt = 0; lowd = -1; lowm = -1;
    if (!ns) begin
      for (int i = 0; i < SLOTS; i++) begin
        if (m_valid[i] && m_tag[i] == t) begin
          cnt++;
          if (lowm < 0) lowm = i;
          if (m_dirty[i] && lowd < 0) lowd = i;
        end
      end
    end
    if (cnt > 0) begin
      surv = (lowd >= 0) ? lowd : lowm;
      for (int i = 0; i < SLOTS; i++) begin
        if (m_valid[i] && m_tag[i] == t && i != surv) begin
          m_valid[i] = 0; m_dirty[i] = 0;
        end
      end
      if (w) m_dirty[surv] = 1;
      e_hit = 1; e_dup = (cnt > 1); e_slot = surv;
    end else begin
      fr = -1;
      for (int i = SLOTS - 1; i >= 0; i--) if (!m_valid[i]) fr = i;
      if (fr < 0) begin
        fr = m_ptr;
        e_wb = m_dirty[fr];
        e_wbtag = e_wb ? m_tag[fr] : 0;
        m_ptr = (m_ptr + 1) % SLOTS;
      end
      m_valid[fr] = 1; m_dirty[fr] = w; m_tag[fr] = t;
      e_slot = fr;
    end
  endtask

  // one request per cycle: drive on a falling edge, compare at the next one
  task automatic step(input string req, input bit v, input bit w, input bit ns, input int unsigned t);
    req_valid = v; req_write = w; req_nosearch = ns; req_tag = TAG_W'(t);
    model_step(v, w, ns, t);
    @(negedge clk);
    chk(req, "rsp_valid", rsp_valid, e_valid);
    chk(req, "rsp_hit",   rsp_hit,   e_hit);
    chk(req, "rsp_slot",  rsp_slot,  e_slot);
    chk(req, "dup_fault", dup_fault, e_dup);
    chk(req, "wb_req",    wb_req,    e_wb);
    chk(req, "wb_tag",    wb_tag,    e_wbtag);
  endtask

  initial begin
    req_valid = 0; req_write = 0; req_nosearch = 0; req_tag = '0;
    rst_n = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk("R1", "rsp_valid", rsp_valid, 0);
    chk("R1", "wb_req", wb_req, 0);
    chk("R1", "dup_fault", dup_fault, 0);
    step("R1", 1, 0, 0, 5);                 // miss into slot 0
    chk("R1", "first fill slot", rsp_slot, 0);
    step("R2", 1, 0, 0, 5);                 // single hit
    chk("R2", "hit slot", rsp_slot, 0);
    step("R9", 0, 0, 0, 0);                 // idle
    step("R8", 1, 1, 1, 5);                 // racing dirty copy -> slot 1
    chk("R8", "nosearch slot", rsp_slot, 1);
    step("R8", 1, 0, 1, 5);                 // racing clean copy -> slot 2
    step("R7", 1, 0, 0, 5);                 // scrub: dirty slot 1 survives
    chk("R7", "dirty survivor", rsp_slot, 1);
    chk("R7", "fault pulse", dup_fault, 1);
    step("R7", 1, 0, 0, 5);                 // copies gone
    chk("R7", "no second fault", dup_fault, 0);
    step("R3", 1, 0, 0, 9);                 // freed slot 0 reused
    chk("R3", "lowest free", rsp_slot, 0);
    step("R7", 1, 1, 1, 7);                 // two dirty copies: slots 2, 3
    step("R7", 1, 1, 1, 7);
    step("R7", 1, 0, 0, 7);
    chk("R7", "lowest dirty survivor", rsp_slot, 2);
    step("R6", 1, 1, 0, 9);                 // write hit makes slot 0 dirty
    for (int i = 0; i < SLOTS; i++) step("R3", 1, (i % 2) == 0, 0, 100 + i);
    for (int i = 0; i < SLOTS + 3; i++) step("R4", 1, 0, 0, 200 + i);   // evictions, wrap
    step("R5", 1, 0, 0, 300);

    // constrained random phase, fixed seed
    void'($urandom(32'h5eed_0713));
    for (int n = 0; n < 4000; n++) begin
      int unsigned r, t;
      bit v, w, ns;
      r  = $urandom_range(0, 99);
      v  = (r >= 20);
      w  = ($urandom_range(0, 2) == 0);
      ns = ($urandom_range(0, 6) == 0);
      t  = $urandom_range(0, 13);
      step("R2/R3/R4/R5/R7 random", v, w, ns, t);
    end
    // R9: quiet after random phase
    step("R9", 0, 1, 0, 3);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule